// File: doc/BRIEF.md
# Frame Descriptor Ring Manager

This block tracks the ownership of a circular list of frame-buffer descriptors that software and a MAC datapath share, for one direction of traffic. Each descriptor in memory occupies three 32-bit words: buffer start address, frame length in bytes, and a status word. The block holds no descriptor contents. It keeps the two ring positions and an occupancy count, and it gives both sides the memory address of the descriptor they should touch next.

A parameter selects the direction. In the transmit variant, software fills the slot at the producer position and strobes `sw_done`. Hardware drains slots at the consumer position and strobes `hw_done`. In the receive variant the roles swap: hardware fills slots and software drains them. A single `sw_busy` flag is 0 whenever the slot at `sw_index` belongs to software. It is 1 when a transmit ring is full or a receive ring is empty. An interrupt, gated by a mask, reports that a slot is available to software. The ring length is programmed as the descriptor count minus one.

Top module: `desc_ring_mgr`

## Requirements
- R1: After reset both indices are 0, the occupancy is 0 and `irq` is 0. With the default 16-slot length limit, `sw_busy` reads 0 for transmit and 1 for receive. `hw_ready` reads 0 for transmit and 1 for receive.
- R2: `sw_desc_addr` equals the ring base plus 12 times `sw_index`, and `hw_desc_addr` equals the ring base plus 12 times `hw_index`. Each descriptor is three 32-bit words.
- R3: Every index stays within 0 to `cfg_last`, and an index that advances from `cfg_last` returns to 0.
- R4: Transmit: an accepted `sw_done` advances `sw_index` (producer) and adds one to occupancy. An accepted `hw_done` advances `hw_index` (consumer) and removes one. `sw_busy` is 1 exactly when occupancy equals `cfg_last`+1. `hw_ready` is 1 exactly when occupancy is nonzero.
- R5: A `sw_done` seen while `sw_busy` is 1 is ignored, and a `hw_done` seen while `hw_ready` is 0 is ignored.
- R6: `cfg_base` and `cfg_last` are captured on `cfg_we` only while `cfg_en` is 0. Such a write also clears both indices, the occupancy and all error bits. A write while `cfg_en` is 1 changes nothing.
- R7: While `cfg_en` is 0, `sw_done` and `hw_done` have no effect.
- R8: `irq` equals `cfg_en & irq_en & ~sw_busy` as sampled one clock earlier.
- R9: Receive: an accepted `hw_done` advances `hw_index` (producer) and adds one to occupancy. An accepted `sw_done` advances `sw_index` (consumer) and removes one. `sw_busy` is 1 exactly when occupancy is 0. `hw_ready` is 1 exactly when occupancy is below `cfg_last`+1.
- R10: An accepted `hw_done` stores `hw_err` as the error bit of the slot at `hw_index`. `sw_slot_err` shows the stored bit for the slot at `sw_index`. A slot with its error bit set is still released by `sw_done` like any other slot.
- R11: When `sw_done` and `hw_done` are both accepted in one cycle, both indices advance and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Direction enable; gates all strobes |
| cfg_we | input | 1 | Ring configuration write strobe |
| cfg_base | input | ADDR_W | Byte address of descriptor 0 |
| cfg_last | input | IDX_W | Descriptor count minus one |
| irq_en | input | 1 | Interrupt mask bit (1 = enabled) |
| sw_done | input | 1 | Software hands its current slot over |
| hw_done | input | 1 | Hardware hands its current slot over |
| hw_err | input | 1 | Error status qualifying `hw_done` |
| sw_index | output | IDX_W | Slot software works on next |
| sw_desc_addr | output | ADDR_W | Descriptor address of `sw_index` |
| sw_busy | output | 1 | 0 when the software slot is owned by software |
| sw_slot_err | output | 1 | Stored error bit of the software slot |
| hw_index | output | IDX_W | Slot hardware works on next |
| hw_desc_addr | output | ADDR_W | Descriptor address of `hw_index` |
| hw_ready | output | 1 | Hardware owns at least one slot |
| irq | output | 1 | Registered slot-available interrupt |

## Verification
A wrong occupancy count appears on `sw_busy` and `hw_ready` in the first cycle after the bad update. It also appears as strobes that are accepted when they should be refused, or refused when they should be accepted. That fault then moves an index, which shows on the index and descriptor-address outputs one clock later. A bad wrap shows as an index above `cfg_last` or an address outside the ring on the very next edge. The bench runs a reference model of both directions in parallel over every ring length the small configuration allows. Each cycle it compares every output, so any divergence is caught within one clock.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  typedef enum logic [0:0] {
    RING_TX = 1'b0,
    RING_RX = 1'b1
  } ring_dir_e;

  localparam int DESC_WORDS = 3;
  localparam int DESC_BYTES = DESC_WORDS * 4;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr) begin
      idx_d = '0;
    end else if (adv) begin
      idx_d = (idx_q == last) ? '0 : idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/ring_occ.sv
module ring_occ #(
  parameter int IDX_W = 4,
  localparam int OCC_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  input  logic [IDX_W-1:0] last,
  output logic [OCC_W-1:0] occ,
  output logic             full,
  output logic             empty
);
  logic [OCC_W-1:0] occ_q, occ_d;

  always_comb begin
    occ_d = occ_q;
    if (clr) begin
      occ_d = '0;
    end else if (inc && !dec) begin
      occ_d = occ_q + OCC_W'(1);
    end else if (dec && !inc) begin
      occ_d = occ_q - OCC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assign occ   = occ_q;
  assign full  = (occ_q == ({1'b0, last} + OCC_W'(1)));
  assign empty = (occ_q == '0);
endmodule

// File: rtl/desc_ring_mgr.sv
module desc_ring_mgr
  import desc_ring_pkg::*;
#(
  parameter int        ADDR_W = 32,
  parameter int        IDX_W  = 4,
  parameter ring_dir_e DIR    = RING_TX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_last,
  input  logic              irq_en,
  input  logic              sw_done,
  input  logic              hw_done,
  input  logic              hw_err,
  output logic [IDX_W-1:0]  sw_index,
  output logic [ADDR_W-1:0] sw_desc_addr,
  output logic              sw_busy,
  output logic              sw_slot_err,
  output logic [IDX_W-1:0]  hw_index,
  output logic [ADDR_W-1:0] hw_desc_addr,
  output logic              hw_ready,
  output logic              irq
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int OCC_W = IDX_W + 1;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [IDX_W-1:0]  last_q, last_d;
  logic [SLOTS-1:0]  err_q, err_d;
  logic              irq_q, irq_d;
  logic [OCC_W-1:0]  occ_w;
  logic              full_w, empty_w;
  logic              cfg_take, sw_acc, hw_acc;
  logic              prod_adv, cons_adv;
  logic [IDX_W-1:0]  prod_idx, cons_idx;

  assign cfg_take = cfg_we & ~cfg_en;

  // configuration capture, locked while the direction runs
  always_comb begin
    base_d = base_q;
    last_d = last_q;
    if (cfg_take) begin
      base_d = cfg_base;
      last_d = cfg_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      last_q <= '0;
    end else begin
      base_q <= base_d;
      last_q <= last_d;
    end
  end

  // direction-specific ownership rules
  generate
    if (DIR == RING_TX) begin : g_tx
      assign sw_busy  = full_w;
      assign hw_ready = ~empty_w;
      assign prod_adv = sw_acc;
      assign cons_adv = hw_acc;
      assign sw_index = prod_idx;
      assign hw_index = cons_idx;
    end else begin : g_rx
      assign sw_busy  = empty_w;
      assign hw_ready = ~full_w;
      assign prod_adv = hw_acc;
      assign cons_adv = sw_acc;
      assign sw_index = cons_idx;
      assign hw_index = prod_idx;
    end
  endgenerate

  assign sw_acc = cfg_en & sw_done & ~sw_busy;
  assign hw_acc = cfg_en & hw_done & hw_ready;

  ring_ptr #(.IDX_W(IDX_W)) u_prod (
    .clk(clk), .rst_n(rst_n), .clr(cfg_take), .adv(prod_adv),
    .last(last_q), .idx(prod_idx)
  );

  ring_ptr #(.IDX_W(IDX_W)) u_cons (
    .clk(clk), .rst_n(rst_n), .clr(cfg_take), .adv(cons_adv),
    .last(last_q), .idx(cons_idx)
  );

  ring_occ #(.IDX_W(IDX_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .clr(cfg_take), .inc(prod_adv),
    .dec(cons_adv), .last(last_q), .occ(occ_w), .full(full_w),
    .empty(empty_w)
  );

  // per-slot error status written by hardware
  always_comb begin
    err_d = err_q;
    if (cfg_take) begin
      err_d = '0;
    end else if (hw_acc) begin
      err_d[hw_index] = hw_err;
    end
  end

  always_comb begin
    irq_d = cfg_en & irq_en & ~sw_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      irq_q <= 1'b0;
    end else begin
      err_q <= err_d;
      irq_q <= irq_d;
    end
  end

  assign sw_slot_err  = err_q[sw_index];
  assign irq          = irq_q;
  assign sw_desc_addr = base_q + (ADDR_W'(sw_index) * ADDR_W'(DESC_BYTES));
  assign hw_desc_addr = base_q + (ADDR_W'(hw_index) * ADDR_W'(DESC_BYTES));
endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  localparam int OCC_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              cfg_we,
  input logic              irq_en,
  input logic              sw_done,
  input logic              hw_done,
  input logic [IDX_W-1:0]  sw_index,
  input logic [IDX_W-1:0]  hw_index,
  input logic              sw_busy,
  input logic              hw_ready,
  input logic              irq,
  input logic [OCC_W-1:0]  occ,
  input logic [ADDR_W-1:0] base_q,
  input logic [IDX_W-1:0]  last_q
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ({1'b0, last_q} + OCC_W'(1))); // R4

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_index <= last_q) && (hw_index <= last_q)); // R3

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && sw_done && !sw_busy && (sw_index == last_q) |=> (sw_index == '0)); // R3

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && sw_done && sw_busy |=> $stable(sw_index)); // R5

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(base_q) && $stable(last_q)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en && !cfg_we |=> $stable(occ) && $stable(sw_index) && $stable(hw_index)); // R7

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq); // R8

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && sw_done && hw_done && !sw_busy && hw_ready |=> $stable(occ)); // R11
endmodule

bind desc_ring_mgr desc_ring_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we), .irq_en(irq_en),
  .sw_done(sw_done), .hw_done(hw_done), .sw_index(sw_index), .hw_index(hw_index),
  .sw_busy(sw_busy), .hw_ready(hw_ready), .irq(irq), .occ(occ_w),
  .base_q(base_q), .last_q(last_q)
);

// File: tb/sim_desc_ring_mgr.sv
module sim_desc_ring_mgr;
  import desc_ring_pkg::*;

  localparam int AW = 32;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_we = 1'b0, irq_en = 1'b0;
  logic sw_done = 1'b0, hw_done = 1'b0, hw_err = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [IW-1:0] cfg_last = '0;

  logic [IW-1:0] o_swi [2];
  logic [IW-1:0] o_hwi [2];
  logic [AW-1:0] o_swa [2];
  logic [AW-1:0] o_hwa [2];
  logic          o_busy[2];
  logic          o_err [2];
  logic          o_rdy [2];
  logic          o_irq [2];

  always #10 clk = ~clk; // 50 MHz

  desc_ring_mgr #(.ADDR_W(AW), .IDX_W(IW), .DIR(RING_TX)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_base(cfg_base), .cfg_last(cfg_last), .irq_en(irq_en),
    .sw_done(sw_done), .hw_done(hw_done), .hw_err(hw_err),
    .sw_index(o_swi[0]), .sw_desc_addr(o_swa[0]), .sw_busy(o_busy[0]),
    .sw_slot_err(o_err[0]), .hw_index(o_hwi[0]), .hw_desc_addr(o_hwa[0]),
    .hw_ready(o_rdy[0]), .irq(o_irq[0])
  );

  desc_ring_mgr #(.ADDR_W(AW), .IDX_W(IW), .DIR(RING_RX)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_base(cfg_base), .cfg_last(cfg_last), .irq_en(irq_en),
    .sw_done(sw_done), .hw_done(hw_done), .hw_err(hw_err),
    .sw_index(o_swi[1]), .sw_desc_addr(o_swa[1]), .sw_busy(o_busy[1]),
    .sw_slot_err(o_err[1]), .hw_index(o_hwi[1]), .hw_desc_addr(o_hwa[1]),
    .hw_ready(o_rdy[1]), .irq(o_irq[1])
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model, index 0 = transmit, 1 = receive
  int m_prod[2], m_cons[2], m_occ[2], m_irq[2];
  bit [3:0] m_err[2];
  int m_base = 0, m_last = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int nx(int i);
    return (i == m_last) ? 0 : i + 1;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    for (int d = 0; d < 2; d++) begin
      int swi, hwi;
      bit busy, rdy;
      swi  = (d == 0) ? m_prod[d] : m_cons[d];
      hwi  = (d == 0) ? m_cons[d] : m_prod[d];
      busy = (d == 0) ? (m_occ[d] == m_last + 1) : (m_occ[d] == 0);
      rdy  = (d == 0) ? (m_occ[d] != 0) : (m_occ[d] != m_last + 1);
      chk($sformatf("%s R3 R4 R9 dir%0d", tag, d), "sw_index", o_swi[d], swi);
      chk($sformatf("%s R3 R4 R9 dir%0d", tag, d), "hw_index", o_hwi[d], hwi);
      chk($sformatf("%s R4 R5 R9 dir%0d", tag, d), "sw_busy", o_busy[d], busy);
      chk($sformatf("%s R4 R5 R9 dir%0d", tag, d), "hw_ready", o_rdy[d], rdy);
      chk($sformatf("%s R2 dir%0d", tag, d), "sw_desc_addr", o_swa[d],
          32'(m_base + swi * 12));
      chk($sformatf("%s R2 dir%0d", tag, d), "hw_desc_addr", o_hwa[d],
          32'(m_base + hwi * 12));
      chk($sformatf("%s R10 dir%0d", tag, d), "sw_slot_err", o_err[d], m_err[d][swi]);
      chk($sformatf("%s R8 dir%0d", tag, d), "irq", o_irq[d], m_irq[d]);
    end
  endtask

  task automatic cycle(bit en, bit we, int base, int last, bit ie,
                       bit sd, bit hd, bit he, string tag);
    cfg_en = en; cfg_we = we; cfg_base = AW'(base); cfg_last = IW'(last);
    irq_en = ie; sw_done = sd; hw_done = hd; hw_err = he;
    for (int d = 0; d < 2; d++) begin
      bit busy, rdy, sa, ha;
      int hwi;
      busy = (d == 0) ? (m_occ[d] == m_last + 1) : (m_occ[d] == 0);
      rdy  = (d == 0) ? (m_occ[d] != 0) : (m_occ[d] != m_last + 1);
      m_irq[d] = en && ie && !busy;
      if (we && !en) begin
        m_prod[d] = 0; m_cons[d] = 0; m_occ[d] = 0; m_err[d] = '0;
      end else if (en) begin
        sa  = sd && !busy;
        ha  = hd && rdy;
        hwi = (d == 0) ? m_cons[d] : m_prod[d];
        if (ha) m_err[d][hwi] = he;
        if (d == 0) begin
          if (sa) m_prod[d] = nx(m_prod[d]);
          if (ha) m_cons[d] = nx(m_cons[d]);
          m_occ[d] += int'(sa) - int'(ha);
        end else begin
          if (ha) m_prod[d] = nx(m_prod[d]);
          if (sa) m_cons[d] = nx(m_cons[d]);
          m_occ[d] += int'(ha) - int'(sa);
        end
      end
    end
    if (we && !en) begin
      m_base = base; m_last = last;
    end
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [15:0] step_lfsr(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_prod[d] = 0; m_cons[d] = 0; m_occ[d] = 0; m_irq[d] = 0; m_err[d] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    for (int last = 0; last < 4; last++) begin
      int base;
      base = 32'h1000 + last * 32'h140;
      cycle(0, 1, base, last, 0, 0, 0, 0, "R6");
      cycle(1, 1, 32'h7777, 3 - last, 1, 0, 0, 0, "R6");
      for (int k = 0; k < last + 3; k++) cycle(1, 0, 0, 0, 1, 1, 0, 0, "R4 R5");
      for (int k = 0; k < last + 3; k++) cycle(1, 0, 0, 0, 1, 0, 1, k[0], "R9 R10");
      for (int k = 0; k < last + 3; k++) cycle(1, 0, 0, 0, 1, 1, 0, 0, "R5 R10");
      for (int k = 0; k < 6; k++) cycle(1, 0, 0, 0, 1, 1, 1, k[1], "R11");
      for (int k = 0; k < 4; k++) cycle(0, 0, 0, 0, 1, 1, 1, 1, "R7");
      for (int k = 0; k < 60; k++) begin
        lfsr = step_lfsr(lfsr);
        cycle(lfsr[0] | lfsr[1], 0, 0, 0, lfsr[2] | lfsr[7], lfsr[3],
              lfsr[4] | lfsr[8], lfsr[5], "R3 R7 R8 R10");
      end
      cycle(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule